// File: doc/BRIEF.md
# CAN Multi-Screener Acceptance Filter

This block decides whether a received CAN frame is kept. Its inputs are the fields of a frame that has already been parsed: the identifier, the extended-format flag, the remote-request flag, the data length code and the first two data bytes. A one-cycle strobe marks a new frame. The frame is compared against a bank of programmable screeners. Each screener holds a 32-bit match word and a 32-bit mask word. A mask bit of 1 makes that bit position don't-care.

A static mode input sets how the frame is packed into the compare word and how the screener words are read. In extended mode there are four screeners, and each compares the 29-bit identifier and the remote flag. In standard mode there are four screeners, and each compares the 11-bit identifier, the remote flag and both leading data bytes. In split mode each word is cut into two screeners, which gives eight in total. The even-numbered screener of each pair also compares data byte 0.

Software writes land in shadow registers. The shadow contents move into the active bank only in a cycle without a frame strobe. A frame is therefore always judged against one consistent set of values, and the bank can be rewritten while traffic flows.

Top module: `can_screen_filter`

## Requirements
- R1: `acc_valid` is high exactly in the cycle after a cycle with `frm_valid` high. `acc_hit` and `acc_idx` are updated in that same cycle. While `acc_valid` is low, `acc_hit` is 0. After reset all three outputs are 0.
- R2: A screener matches when every bit whose mask bit is 0 equals the corresponding match bit. Mask bits of 1 are don't-care.
- R3: In mode 0 (extended), the compare word is bits 31:3 = ID[28:0] and bit 2 = RTR. Bits 1:0 are ignored. Only frames with `frm_ide`=1 can be accepted.
- R4: In mode 1 (standard), the compare word is bits 31:21 = ID[10:0], bit 20 = RTR, bits 15:8 = data byte 0 and bits 7:0 = data byte 1. Bits 19:16 are ignored. In modes 1 and 2 only frames with `frm_ide`=0 can be accepted.
- R5: In mode 2 (split), word k supplies two screeners:
  - Screener 2k uses bits 31:12: ID[10:0] at 31:21, RTR at 20 and data byte 0 at 19:12.
  - Screener 2k+1 uses bits 11:0: ID[10:0] at 11:1 and RTR at bit 0.
- R6: A data byte n that is compared but not present in the frame (data length code ≤ n) counts as a mismatch unless all 8 of its mask bits are 1. When RTR=1, the data-byte fields are not compared at all.
- R7: When several screeners match, `acc_idx` reports the lowest index. With no match, `acc_idx` is 0.
- R8: Mode 3 accepts no frame.
- R9: Each write sets a shadow word:
  - `wr_en` writes `wr_data` into the shadow word of screener `wr_idx`.
  - `wr_mask`=1 selects the mask word and `wr_mask`=0 the match word.
  - All shadow words are copied into the active bank at the end of every cycle with `frm_valid` low.
  - While strobes arrive back to back, the active bank stays unchanged.
- R10: After reset every match and mask word is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | 0 extended, 1 standard, 2 split, 3 reject all |
| frm_valid | input | 1 | One-cycle strobe for a parsed frame |
| frm_ide | input | 1 | 1 for an extended-format frame |
| frm_rtr | input | 1 | Remote-request flag |
| frm_id | input | 29 | Identifier; standard frames use bits 10:0 |
| frm_dlc | input | 4 | Data length code |
| frm_d0 | input | 8 | First data byte |
| frm_d1 | input | 8 | Second data byte |
| wr_en | input | 1 | Screener write strobe |
| wr_idx | input | 2 | Screener word to write |
| wr_mask | input | 1 | 1 selects the mask word, 0 the match word |
| wr_data | input | 32 | Write value |
| acc_valid | output | 1 | Decision valid |
| acc_hit | output | 1 | Frame accepted |
| acc_idx | output | 3 | Index of the lowest matching screener |

## Verification
The decision for a frame strobed in one cycle is due one rising edge later. The bench drives every input on the falling edge and reads `acc_valid`, `acc_hit` and `acc_idx` on the next falling edge. A write takes effect only after a strobe-free cycle has passed. For this reason the write task holds one idle cycle before any frame that relies on the new value. The reconfiguration test instead streams strobes with no gap while it writes, and at each falling edge it checks that the old decisions persist. It then leaves one idle cycle, after which it expects the new result.

// File: rtl/can_screen_filter.sv
module can_screen_filter #(
  parameter int NSCR = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_mode,
  input  logic                     frm_valid,
  input  logic                     frm_ide,
  input  logic                     frm_rtr,
  input  logic [28:0]              frm_id,
  input  logic [3:0]               frm_dlc,
  input  logic [7:0]               frm_d0,
  input  logic [7:0]               frm_d1,
  input  logic                     wr_en,
  input  logic [$clog2(NSCR)-1:0]  wr_idx,
  input  logic                     wr_mask,
  input  logic [31:0]              wr_data,
  output logic                     acc_valid,
  output logic                     acc_hit,
  output logic [$clog2(2*NSCR)-1:0] acc_idx
);

  localparam int NH = 2 * NSCR;
  localparam int IW = $clog2(NH);

  logic [NSCR-1:0][31:0] sh_match, sh_mask, ac_match, ac_mask;
  logic [NSCR-1:0][31:0] dif;
  logic [31:0] fw, care, miss;
  logic        ide_ok, split, d0_abs, d1_abs;
  logic [NSCR-1:0] hf;
  logic [NH-1:0]   hs, cand;
  logic            hit_n;
  logic [IW-1:0]   idx_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_match <= '0;
      sh_mask  <= '0;
    end else if (wr_en) begin
      if (wr_mask) sh_mask[wr_idx]  <= wr_data;
      else         sh_match[wr_idx] <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ac_match <= '0;
      ac_mask  <= '0;
    end else if (!frm_valid) begin
      ac_match <= sh_match;
      ac_mask  <= sh_mask;
    end

  assign d0_abs = !frm_rtr && (frm_dlc == 4'd0);
  assign d1_abs = !frm_rtr && (frm_dlc < 4'd2);
  assign split  = (cfg_mode == 2'd2);

  always_comb begin
    fw = '0; care = '0; miss = '0; ide_ok = 1'b0;
    case (cfg_mode)
      2'd0: begin
        fw     = {frm_id, frm_rtr, 2'b00};
        care   = 32'hFFFF_FFFC;
        ide_ok = frm_ide;
      end
      2'd1: begin
        fw     = {frm_id[10:0], frm_rtr, 4'h0, frm_d0, frm_d1};
        care   = frm_rtr ? 32'hFFF0_0000 : 32'hFFF0_FFFF;
        miss   = {16'h0, {8{d0_abs}}, {8{d1_abs}}};
        ide_ok = !frm_ide;
      end
      2'd2: begin
        fw     = {frm_id[10:0], frm_rtr, frm_d0, frm_id[10:0], frm_rtr};
        care   = frm_rtr ? 32'hFFF0_0FFF : 32'hFFFF_FFFF;
        miss   = {12'h0, {8{d0_abs}}, 12'h0};
        ide_ok = !frm_ide;
      end
      default: ;
    endcase
  end

  for (genvar k = 0; k < NSCR; k++) begin : g_scr
    assign dif[k]      = ((fw ^ ac_match[k]) | miss) & ~ac_mask[k] & care;
    assign hf[k]       = ide_ok && (dif[k] == '0);
    assign hs[2*k]     = ide_ok && (dif[k][31:12] == '0);
    assign hs[2*k+1]   = ide_ok && (dif[k][11:0] == '0);
  end

  assign cand = split ? hs : {{NSCR{1'b0}}, hf};

  always_comb begin
    hit_n = 1'b0;
    idx_n = '0;
    for (int i = NH - 1; i >= 0; i--)
      if (cand[i]) begin
        hit_n = 1'b1;
        idx_n = IW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_hit   <= 1'b0;
      acc_idx   <= '0;
    end else begin
      acc_valid <= frm_valid;
      acc_hit   <= frm_valid && hit_n;
      acc_idx   <= frm_valid ? idx_n : '0;
    end

  a_r1_strobe_lat: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> acc_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !acc_valid);
  a_r1_hit_qual: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> acc_valid);
  a_r7_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> (acc_idx == '0));
  a_r8_reject_all: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && cfg_mode == 2'd3) |=> !acc_hit);
  a_r3_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && cfg_mode == 2'd0 && !frm_ide) |=> !acc_hit);
  a_r4_std_only: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && (cfg_mode == 2'd1 || cfg_mode == 2'd2) && frm_ide) |=> !acc_hit);
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && cfg_mode != 2'd2) |=> (acc_idx < IW'(NSCR)));
  a_r9_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> ($stable(ac_match) && $stable(ac_mask)));

endmodule

// File: tb/sim_can_screen_filter.sv
module sim_can_screen_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        frm_valid = 1'b0, frm_ide = 1'b0, frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [7:0]  frm_d0 = '0, frm_d1 = '0;
  logic        wr_en = 1'b0, wr_mask = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        acc_valid, acc_hit;
  logic [2:0]  acc_idx;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_screen_filter u0 (
    .clk, .rst_n, .cfg_mode, .frm_valid, .frm_ide, .frm_rtr, .frm_id,
    .frm_dlc, .frm_d0, .frm_d1, .wr_en, .wr_idx, .wr_mask, .wr_data,
    .acc_valid, .acc_hit, .acc_idx
  );

  task automatic chk(input string tag, input bit ev, input bit eh, input int ei);
    checks++;
    if (acc_valid !== ev || acc_hit !== eh || acc_idx !== ei[2:0]) begin
      errors++;
      $display("FAIL %s: valid=%0b hit=%0b idx=%0d expected valid=%0b hit=%0b idx=%0d",
               tag, acc_valid, acc_hit, acc_idx, ev, eh, ei);
    end
  endtask

  task automatic put(input bit ide, input bit rtr, input logic [28:0] id,
                     input logic [3:0] dlc, input logic [7:0] d0, input logic [7:0] d1);
    frm_valid = 1'b1; frm_ide = ide; frm_rtr = rtr; frm_id = id;
    frm_dlc = dlc; frm_d0 = d0; frm_d1 = d1;
  endtask

  task automatic send(input string tag, input bit ide, input bit rtr, input logic [28:0] id,
                      input logic [3:0] dlc, input logic [7:0] d0, input logic [7:0] d1,
                      input bit eh, input int ei);
    put(ide, rtr, id, dlc, d0, d1);
    @(negedge clk);
    frm_valid = 1'b0;
    chk(tag, 1'b1, eh, ei);
  endtask

  task automatic wr(input logic [1:0] idx, input bit m, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_mask = m; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset outputs", 1'b0, 1'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 1'b0, 1'b0, 0);
    cfg_mode = 2'd0;
    send("R10 zero bank accepts id 0", 1, 0, 29'h0, 4'd0, 8'h0, 8'h0, 1, 0);
    send("R10 zero bank rejects id 1", 1, 0, 29'h1, 4'd0, 8'h0, 8'h0, 0, 0);
  endtask

  task automatic t_ext;
    cfg_mode = 2'd0;
    wr(2'd1, 0, 32'h091A_2B3B);
    wr(2'd2, 0, 32'h091A_2B38);
    wr(2'd2, 1, 32'h0000_00F8);
    send("R3 ext match, low bits ignored", 1, 0, 29'h1234567, 4'd8, 8'h0, 8'h0, 1, 1);
    send("R3 ext rtr differs", 1, 1, 29'h1234567, 4'd8, 8'h0, 8'h0, 0, 0);
    send("R3 standard frame rejected", 0, 0, 29'h1234567, 4'd8, 8'h0, 8'h0, 0, 0);
    send("R2 masked id bits", 1, 0, 29'h1234578, 4'd8, 8'h0, 8'h0, 1, 2);
    send("R2 unmasked id bit differs", 1, 0, 29'h1234547, 4'd8, 8'h0, 8'h0, 0, 0);
  endtask

  task automatic t_std;
    cfg_mode = 2'd1;
    wr(2'd0, 0, 32'h246F_AA55);
    wr(2'd3, 0, 32'h2470_0000);
    send("R4 std id and both bytes", 0, 0, 29'h123, 4'd8, 8'hAA, 8'h55, 1, 0);
    send("R4 byte 1 differs", 0, 0, 29'h123, 4'd8, 8'hAA, 8'h54, 0, 0);
    send("R4 extended frame rejected", 1, 0, 29'h123, 4'd8, 8'hAA, 8'h55, 0, 0);
    send("R6 absent byte 1 mismatches", 0, 0, 29'h123, 4'd1, 8'hAA, 8'h55, 0, 0);
    wr(2'd2, 0, 32'h2460_AA00);
    wr(2'd2, 1, 32'h0000_00FF);
    send("R6 absent byte fully masked", 0, 0, 29'h123, 4'd1, 8'hAA, 8'h55, 1, 2);
    send("R6 absent byte 0 mismatches", 0, 0, 29'h123, 4'd0, 8'hAA, 8'h55, 0, 0);
    send("R6 remote frame skips data", 0, 1, 29'h123, 4'd0, 8'h77, 8'h88, 1, 3);
  endtask

  task automatic t_split;
    cfg_mode = 2'd2;
    wr(2'd1, 0, 32'h78A5_A0FE);
    send("R5 upper half id and byte 0", 0, 0, 29'h3C5, 4'd1, 8'h5A, 8'h0, 1, 2);
    send("R5 upper half byte 0 differs", 0, 0, 29'h3C5, 4'd1, 8'h5B, 8'h0, 0, 0);
    send("R5 lower half id only", 0, 0, 29'h07F, 4'd0, 8'h00, 8'h0, 1, 3);
    send("R6 split byte 0 absent", 0, 0, 29'h3C5, 4'd0, 8'h5A, 8'h0, 0, 0);
    send("R7 top index 7", 0, 0, 29'h000, 4'd0, 8'h00, 8'h0, 1, 7);
  endtask

  task automatic t_mode3;
    cfg_mode = 2'd3;
    send("R8 reject-all mode", 0, 0, 29'h3C5, 4'd1, 8'h5A, 8'h0, 0, 0);
    send("R8 reject-all mode, id 0", 0, 0, 29'h000, 4'd0, 8'h00, 8'h0, 0, 0);
  endtask

  task automatic t_atomic;
    cfg_mode = 2'd0;
    put(1, 0, 29'h1, 4'd0, 8'h0, 8'h0);
    wr_en = 1'b1; wr_idx = 2'd0; wr_mask = 1'b0; wr_data = 32'h0;
    @(negedge clk);
    wr_mask = 1'b1; wr_data = 32'hFFFF_FFFF;
    chk("R9 old bank during stream a", 1'b1, 1'b0, 0);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 old bank during stream b", 1'b1, 1'b0, 0);
    @(negedge clk);
    chk("R9 old bank during stream c", 1'b1, 1'b0, 0);
    @(negedge clk);
    frm_valid = 1'b0;
    chk("R9 old bank during stream d", 1'b1, 1'b0, 0);
    @(negedge clk);
    chk("R1 no decision after idle cycle", 1'b0, 1'b0, 0);
    send("R9 new bank after idle cycle", 1, 0, 29'h1, 4'd0, 8'h0, 8'h0, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ext();
    t_std();
    t_split();
    t_mode3();
    t_atomic();
    @(negedge clk);
    chk("R1 idle at end", 1'b0, 1'b0, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule